// File: doc/BRIEF.md
# Cache ECC Error Reporting Unit

This block sits next to a cache and collects the error events that the cache's ECC checkers raise. It handles three independent classes: correctable errors found in the directory array, correctable errors found in the data array, and uncorrectable errors found in the data array. For each class it keeps the 64-bit address of the latest event and a saturating event count. It drives one level interrupt per class, which stays high until software reads that class's count word.

Software reaches the block through a plain 32-bit register port with separate read and write strobes. The read data is combinational from the address. Besides the per-class words, the port exposes a read-only word that describes the cache geometry. It also exposes a way-enable word that holds the highest enabled way index. A range-checked fault-injection word turns each accepted write into a single-cycle request toward the cache datapath. That request names a bit to flip and selects either the directory array or the data array.

Top module: `ecc_report_unit`

## Requirements
- R1: After reset all counts and captured addresses read as zero. All three interrupts and `inj_pulse` are low. The way-enable word at 0x008 reads WAYS-1.
- R2: An event pulse on a class raises that class's interrupt at the next clock edge. The same edge increments the class's count by one and stores the 64-bit event address. Bits 31:0 of that address read back at the class base, and bits 63:32 read back at base+0x4.
- R3: A class count saturates at 2^CNT_W-1. Further events leave it at that value and still raise the interrupt.
- R4: A read (`reg_rd` high) of a class's count word at base+0x8 returns the current count and lowers that class's interrupt at the next edge. Reads of the two address words leave the interrupt unchanged.
- R5: If an event of a class arrives in the same cycle as a read of that class's count word, the read returns the old count. The count still increments, and the interrupt stays high.
- R6: The class bases are 0x100 for directory correctable (`dir_fix_*`), 0x140 for data correctable (`dat_fix_*`) and 0x160 for data uncorrectable (`dat_fail_*`). Events and reads of one class never change another class's count, address or interrupt.
- R7: The word at 0x000 reads {LOG2_BLK[7:0], LOG2_SETS[7:0], WAYS[7:0], NUM_BANKS[7:0]}, with NUM_BANKS in bits 7:0.
- R8: A write to 0x008 whose full 32-bit value is at most WAYS-1 is stored and read back in bits 7:0, with the upper bits zero. Any larger value is ignored.
- R9: A write to 0x040 is accepted when bits 31:17 and 15:8 are zero and bits 7:0 are not 0xFF. One edge later `inj_pulse` is high for exactly one cycle. At the same time `inj_bit` equals bits 7:0 and `inj_dir` equals bit 16. Reading 0x040 returns the last accepted value.
- R10: A write to 0x040 outside the accepted set gives no pulse and leaves the 0x040 readback unchanged.
- R11: Writes to the geometry word, to the class address and count words, and to unmapped offsets change nothing. Reads of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dir_fix_vld | input | 1 | Directory correctable event pulse |
| dir_fix_addr | input | 64 | Address of directory correctable event |
| dat_fix_vld | input | 1 | Data correctable event pulse |
| dat_fix_addr | input | 64 | Address of data correctable event |
| dat_fail_vld | input | 1 | Data uncorrectable event pulse |
| dat_fail_addr | input | 64 | Address of data uncorrectable event |
| dir_fix_irq | output | 1 | Directory correctable interrupt |
| dat_fix_irq | output | 1 | Data correctable interrupt |
| dat_fail_irq | output | 1 | Data uncorrectable interrupt |
| inj_pulse | output | 1 | One-cycle fault-injection request |
| inj_bit | output | 8 | Bit index to flip |
| inj_dir | output | 1 | 1 selects directory array, 0 data array |

## Verification
A wrong count or address shows up on the first read of that class's words after the event. It therefore appears within two cycles of the stimulus. Wrong interrupt set or clear behaviour shows on the irq pin at the edge after the event or after the count read. A saturation fault only appears after 2^CNT_W events, so the bench uses a narrow counter and drives each class past its limit. A wrong range check in the injection word appears as a missing or extra pulse one edge after the write, and as a changed readback of 0x040.

// File: rtl/ecc_report_pkg.sv
package ecc_report_pkg;
  localparam int NCLS = 3;
  localparam int AW   = 12;
  localparam int DW   = 32;

  localparam logic [AW-1:0] OFS_CFG = 12'h000;
  localparam logic [AW-1:0] OFS_WAY = 12'h008;
  localparam logic [AW-1:0] OFS_INJ = 12'h040;

  // base offset of each error class; order: dir fix, data fix, data fail
  function automatic logic [AW-1:0] cls_base(input int idx);
    case (idx)
      0:       return 12'h100;
      1:       return 12'h140;
      default: return 12'h160;
    endcase
  endfunction

  function automatic logic [DW-1:0] pack_cfg(input int banks, input int ways,
                                             input int lsets, input int lblk);
    return {8'(lblk), 8'(lsets), 8'(ways), 8'(banks)};
  endfunction

  function automatic logic inj_legal(input logic [DW-1:0] v);
    return (v[31:17] == '0) && (v[15:8] == '0) && (v[7:0] != 8'hFF);
  endfunction
endpackage

// File: rtl/ecc_reg_decode.sv
module ecc_reg_decode
  import ecc_report_pkg::*;
(
  input  logic [AW-1:0]   addr,
  output logic            sel_cfg,
  output logic            sel_way,
  output logic            sel_inj,
  output logic [NCLS-1:0] sel_lo,
  output logic [NCLS-1:0] sel_hi,
  output logic [NCLS-1:0] sel_cnt,
  output logic            sel_none
);
  assign sel_cfg = (addr == OFS_CFG);
  assign sel_way = (addr == OFS_WAY);
  assign sel_inj = (addr == OFS_INJ);

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    assign sel_lo[g]  = (addr == cls_base(g));
    assign sel_hi[g]  = (addr == cls_base(g) + 12'h4);
    assign sel_cnt[g] = (addr == cls_base(g) + 12'h8);
  end

  assign sel_none = !(sel_cfg || sel_way || sel_inj ||
                      (|sel_lo) || (|sel_hi) || (|sel_cnt));
endmodule

// File: rtl/ecc_err_class.sv
module ecc_err_class #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_vld,
  input  logic [63:0]      evt_addr,
  input  logic             cnt_rd,
  output logic             irq,
  output logic [63:0]      addr_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  logic cnt_at_max;
  assign cnt_at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (evt_vld) begin
        addr_q <= evt_addr;
        cnt_q  <= sat_inc(cnt_q);
      end
      if (evt_vld)     irq <= 1'b1;
      else if (cnt_rd) irq <= 1'b0;
    end
  end

  // R2
  evt_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld |=> irq);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && !cnt_at_max) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_at_max |=> cnt_at_max);
  // R4
  rd_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd && !evt_vld) |=> !irq);
  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_rd && !evt_vld) |=> (irq == $past(irq)));
endmodule

// File: rtl/ecc_inject_ctl.sv
module ecc_inject_ctl
  import ecc_report_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  output logic          inj_pulse,
  output logic [7:0]    inj_bit,
  output logic          inj_dir,
  output logic [DW-1:0] inj_q
);
  logic accept;
  assign accept = wr_hit && inj_legal(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_q     <= '0;
      inj_pulse <= 1'b0;
    end else begin
      inj_pulse <= accept;
      if (accept) inj_q <= wdata;
    end
  end

  assign inj_bit = inj_q[7:0];
  assign inj_dir = inj_q[16];

  // R9
  inj_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> !inj_pulse);
  // R10
  inj_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(inj_q));
endmodule

// File: rtl/ecc_report_unit.sv
module ecc_report_unit
  import ecc_report_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_BANKS = 4,
  parameter int WAYS      = 16,
  parameter int LOG2_SETS = 10,
  parameter int LOG2_BLK  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dir_fix_vld,
  input  logic [63:0]   dir_fix_addr,
  input  logic          dat_fix_vld,
  input  logic [63:0]   dat_fix_addr,
  input  logic          dat_fail_vld,
  input  logic [63:0]   dat_fail_addr,
  output logic          dir_fix_irq,
  output logic          dat_fix_irq,
  output logic          dat_fail_irq,
  output logic          inj_pulse,
  output logic [7:0]    inj_bit,
  output logic          inj_dir
);
  localparam logic [DW-1:0] CFG_WORD = pack_cfg(NUM_BANKS, WAYS, LOG2_SETS, LOG2_BLK);
  localparam logic [DW-1:0] WAY_TOP  = DW'(WAYS - 1);

  logic            sel_cfg, sel_way, sel_inj, sel_none;
  logic [NCLS-1:0] sel_lo, sel_hi, sel_cnt;

  ecc_reg_decode u_dec (
    .addr     (reg_addr),
    .sel_cfg  (sel_cfg),
    .sel_way  (sel_way),
    .sel_inj  (sel_inj),
    .sel_lo   (sel_lo),
    .sel_hi   (sel_hi),
    .sel_cnt  (sel_cnt),
    .sel_none (sel_none)
  );

  logic [NCLS-1:0] evt_vld_a;
  logic [63:0]     evt_addr_a [NCLS];
  logic [NCLS-1:0] irq_a;
  logic [63:0]     addr_q_a   [NCLS];
  logic [CNT_W-1:0] cnt_q_a   [NCLS];
  logic [NCLS-1:0] cnt_rd_a;

  assign evt_vld_a     = {dat_fail_vld, dat_fix_vld, dir_fix_vld};
  assign evt_addr_a[0] = dir_fix_addr;
  assign evt_addr_a[1] = dat_fix_addr;
  assign evt_addr_a[2] = dat_fail_addr;
  assign cnt_rd_a      = sel_cnt & {NCLS{reg_rd}};

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    ecc_err_class #(.CNT_W(CNT_W)) u_cls (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_vld  (evt_vld_a[g]),
      .evt_addr (evt_addr_a[g]),
      .cnt_rd   (cnt_rd_a[g]),
      .irq      (irq_a[g]),
      .addr_q   (addr_q_a[g]),
      .cnt_q    (cnt_q_a[g])
    );
  end

  assign dir_fix_irq  = irq_a[0];
  assign dat_fix_irq  = irq_a[1];
  assign dat_fail_irq = irq_a[2];

  logic [DW-1:0] inj_q;

  ecc_inject_ctl u_inj (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (reg_wr && sel_inj),
    .wdata     (reg_wdata),
    .inj_pulse (inj_pulse),
    .inj_bit   (inj_bit),
    .inj_dir   (inj_dir),
    .inj_q     (inj_q)
  );

  // way-enable word: highest enabled way index
  logic [7:0] way_q;
  logic       way_wr_ok;
  assign way_wr_ok = reg_wr && sel_way && (reg_wdata <= WAY_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         way_q <= 8'(WAYS - 1);
    else if (way_wr_ok) way_q <= reg_wdata[7:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_cfg) reg_rdata = CFG_WORD;
    if (sel_way) reg_rdata = DW'(way_q);
    if (sel_inj) reg_rdata = inj_q;
    for (int i = 0; i < NCLS; i++) begin
      if (sel_lo[i])  reg_rdata = addr_q_a[i][31:0];
      if (sel_hi[i])  reg_rdata = addr_q_a[i][63:32];
      if (sel_cnt[i]) reg_rdata = DW'(cnt_q_a[i]);
    end
  end

  // R8
  way_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    DW'(way_q) <= WAY_TOP);
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_none |-> (reg_rdata == '0));
  // R6
  cls_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_lo, sel_hi, sel_cnt}));
endmodule

// File: tb/test_ecc_report_unit.sv
module test_ecc_report_unit;
  localparam int CNT_W = 4;
  localparam int NB = 2, NW = 4, LS = 5, LB = 6;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam time CLKP = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        vld [3];
  logic [63:0] ea  [3];
  logic [2:0]  irq;
  logic        inj_pulse, inj_dir;
  logic [7:0]  inj_bit;

  int tests = 0, fails = 0;

  always #(CLKP/2) clk = ~clk;

  ecc_report_unit #(.CNT_W(CNT_W), .NUM_BANKS(NB), .WAYS(NW),
                    .LOG2_SETS(LS), .LOG2_BLK(LB)) i_ecc_report_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dir_fix_vld(vld[0]), .dir_fix_addr(ea[0]),
    .dat_fix_vld(vld[1]), .dat_fix_addr(ea[1]),
    .dat_fail_vld(vld[2]), .dat_fail_addr(ea[2]),
    .dir_fix_irq(irq[0]), .dat_fix_irq(irq[1]), .dat_fail_irq(irq[2]),
    .inj_pulse(inj_pulse), .inj_bit(inj_bit), .inj_dir(inj_dir)
  );

  function automatic logic [11:0] base(input int c);
    return (c == 0) ? 12'h100 : (c == 1) ? 12'h140 : 12'h160;
  endfunction

  function automatic logic [63:0] mk_addr(input int c, input int k);
    return {32'(c + 1) * 32'h0101_0101 ^ 32'(k), 32'hA000_0000 + 32'(k * 16)};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic evt(input int c, input logic [63:0] a);
    vld[c] = 1'b1; ea[c] = a;
    @(negedge clk);
    vld[c] = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] inj_exp;
    logic [7:0]  way_exp;
    for (int c = 0; c < 3; c++) begin vld[c] = 1'b0; ea[c] = '0; end
    do_reset();

    // R1 reset state
    check("R1 irq", 64'(irq), 0);
    check("R1 inj_pulse", 64'(inj_pulse), 0);
    for (int c = 0; c < 3; c++)
      for (int w = 0; w < 3; w++) begin
        rd(base(c) + 12'(4 * w), d);
        check("R1 class word", 64'(d), 0);
      end
    rd(12'h008, d); check("R1 way reset", 64'(d), 64'(NW - 1));
    // R7 geometry
    rd(12'h000, d); check("R7 cfg", 64'(d), {32'h0, 8'(LB), 8'(LS), 8'(NW), 8'(NB)});

    // R11 writes to read-only words and unmapped offsets
    wr(12'h000, 32'hFFFF_FFFF);
    for (int c = 0; c < 3; c++)
      for (int w = 0; w < 3; w++) wr(base(c) + 12'(4 * w), 32'hFFFF_FFFF);
    wr(12'h004, 32'h1234_5678);
    check("R11 no inj pulse", 64'(inj_pulse), 0);
    rd(12'h000, d); check("R11 cfg unchanged", 64'(d), {32'h0, 8'(LB), 8'(LS), 8'(NW), 8'(NB)});
    for (int c = 0; c < 3; c++)
      for (int w = 0; w < 3; w++) begin
        rd(base(c) + 12'(4 * w), d);
        check("R11 class word unchanged", 64'(d), 0);
      end
    rd(12'h004, d); check("R11 unmapped 004", 64'(d), 0);
    rd(12'h10C, d); check("R11 unmapped 10C", 64'(d), 0);
    rd(12'h200, d); check("R11 unmapped 200", 64'(d), 0);
    rd(12'hFFC, d); check("R11 unmapped FFC", 64'(d), 0);

    // R5 event coincident with count read (class 1)
    evt(1, mk_addr(1, 99));
    check("R5 irq set", 64'(irq[1]), 1);
    vld[1] = 1'b1; ea[1] = mk_addr(1, 98);
    rd(base(1) + 12'h8, d);
    vld[1] = 1'b0;
    check("R5 old count", 64'(d), 1);
    check("R5 irq kept", 64'(irq[1]), 1);
    rd(base(1) + 12'h8, d);
    check("R5 count incremented", 64'(d), 2);
    check("R5 irq cleared after", 64'(irq[1]), 0);

    do_reset();
    // R2 R3 R4 R6 sweep per class beyond saturation
    for (int c = 0; c < 3; c++) begin
      for (int k = 1; k <= CMAX + 3; k++) begin
        evt(c, mk_addr(c, k));
        check("R2 irq after event", 64'(irq[c]), 1);
        check("R6 other irqs", 64'(irq & ~(3'b1 << c)), 0);
        rd(base(c), d);           check("R2 addr lo", 64'(d), 64'(mk_addr(c, k) & 64'hFFFF_FFFF));
        rd(base(c) + 12'h4, d);   check("R2 addr hi", 64'(d), 64'(mk_addr(c, k) >> 32));
        check("R4 addr reads keep irq", 64'(irq[c]), 1);
        rd(base(c) + 12'h8, d);
        check("R3 count", 64'(d), 64'((k < CMAX) ? k : CMAX));
        check("R4 count read clears irq", 64'(irq[c]), 0);
      end
      for (int o = c + 1; o < 3; o++) begin
        rd(base(o) + 12'h8, d); check("R6 untouched count", 64'(d), 0);
        rd(base(o), d);         check("R6 untouched addr", 64'(d), 0);
      end
    end

    // R8 way-enable write range
    way_exp = 8'(NW - 1);
    for (int v = 0; v < 8; v++) begin
      wr(12'h008, 32'(v));
      if (v <= NW - 1) way_exp = 8'(v);
      rd(12'h008, d);
      check("R8 way", 64'(d), 64'(way_exp));
    end
    wr(12'h008, 32'h0001_0000);
    rd(12'h008, d); check("R8 high bits ignored", 64'(d), 64'(way_exp));

    // R9 R10 injection sweep over low byte with and without directory bit
    inj_exp = '0;
    for (int v = 0; v < 512; v++) begin
      logic [31:0] wv;
      wv = {15'b0, v[8], 8'b0, v[7:0]};
      wr(12'h040, wv);
      if (v[7:0] != 8'hFF) begin
        inj_exp = wv;
        check("R9 pulse", 64'(inj_pulse), 1);
        check("R9 bit", 64'(inj_bit), 64'(v[7:0]));
        check("R9 dir", 64'(inj_dir), 64'(v[8]));
        @(negedge clk);
        check("R9 single cycle", 64'(inj_pulse), 0);
      end else begin
        check("R10 no pulse", 64'(inj_pulse), 0);
        rd(12'h040, d); check("R10 readback kept", 64'(d), 64'(inj_exp));
      end
    end
    rd(12'h040, d); check("R9 readback", 64'(d), 64'(inj_exp));
    for (int j = 0; j < 4; j++) begin
      logic [31:0] bad;
      bad = (j == 0) ? 32'h0000_0100 : (j == 1) ? 32'h0002_0000 :
            (j == 2) ? 32'h8000_0001 : 32'h0001_80FE;
      wr(12'h040, bad);
      check("R10 out of range no pulse", 64'(inj_pulse), 0);
      rd(12'h040, d); check("R10 out of range kept", 64'(d), 64'(inj_exp));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule